// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Controller

The controller sits between an 8-bit processor core and its external bus. The core hands it one read or write request at a time, for either memory or I/O space, over a 16-bit address. The controller turns each request into a bus cycle of three clock states.

The low address byte and the data byte share one 8-bit pad group, `mux_*`. Each pad has separate out, enable and in signals. The upper address byte has its own pins. A strobe marks the state in which the shared pins carry address, so an external latch can capture that byte.

An external master can take the bus with a hold request. The controller grants the request only between cycles and acknowledges it. While the acknowledge is high, every address, data and strobe pad is released. Completion of each cycle, with the read data for reads, is reported back to the core as a one-cycle pulse.

Top module: `muxbus_cycle_ctrl`

## Requirements
- R1: After reset the controller is idle with these output values:
  - `rd_stb_no`, `wr_stb_no` = 1
  - `addr_stb_o`, `mux_oe_o`, `hold_ack_o`, `done_o` = 0
  - `ctl_oe_o` = 1
  - `rdata_o` = 0
- R2: A bus cycle occupies exactly three consecutive clock states, S1, S2 and S3. S1 is the first cycle after the request handshake. `addr_stb_o` is high in S1 only. In S1, `mux_oe_o` = 1 and `mux_o` = address bits [7:0].
- R3: For memory cycles, `addr_hi_o` = address bits [15:8] in S1, S2 and S3.
- R4: `sel_io_o` is 1 for I/O cycles and 0 for memory cycles, in all three states.
- R5: In a read cycle, `mux_oe_o` = 0 in S2 and S3, and `rd_stb_no` = 0 in S2 and S3 only. `wr_stb_no` stays 1.
- R6: In a write cycle, `mux_oe_o` = 1 and `mux_o` = write data in S2 and S3, and `wr_stb_no` = 0 in S2 and S3 only. `rd_stb_no` stays 1.
- R7: In the cycle after S3, `done_o` is high for one cycle, for reads and writes alike. For a read, `rdata_o` then holds the value `mux_i` carried at the clock edge that ends S3. `rdata_o` keeps that value until the next read completes.
- R8: For I/O cycles, the port number (address bits [7:0]) appears on both `mux_o` in S1 and `addr_hi_o` in S1, S2 and S3. Address bits [15:8] are ignored.
- R9: `hold_req_i` is sampled only in the idle state and at the edge ending S3. A hold request raised during S1 or S2 does not change that cycle. `hold_ack_o` rises one cycle after a sampled hold request.
- R10: While `hold_ack_o` = 1, the pads are released: `mux_oe_o` = 0, `ctl_oe_o` = 0, `addr_stb_o` = 0 and both strobes are 1. `hold_ack_o` falls one cycle after `hold_req_i` is seen low.
- R11: `req_ready_o` = 1 only when idle with `hold_req_i` low, so a hold request has priority over a core request. A request is taken when both `req_i` and `req_ready_o` are high.
- R12: The two strobes are never low together, and neither is low while `addr_stb_o` is high.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Core request valid |
| req_ready_o | output | 1 | Controller can take a request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_io_i | input | 1 | 1 = I/O space, 0 = memory |
| req_addr_i | input | 16 | Request address |
| req_wdata_i | input | 8 | Write data |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Data of the last completed read |
| mux_o | output | 8 | Shared pads: address low byte or data out |
| mux_oe_o | output | 1 | Output enable of the shared pads |
| mux_i | input | 8 | Shared pads: data in |
| addr_hi_o | output | 8 | Dedicated upper address pins |
| ctl_oe_o | output | 1 | Output enable of upper address, select and strobe pads |
| addr_stb_o | output | 1 | Address latch strobe |
| sel_io_o | output | 1 | I/O (1) or memory (0) select |
| rd_stb_no | output | 1 | Read strobe, active low |
| wr_stb_no | output | 1 | Write strobe, active low |
| hold_req_i | input | 1 | External master requests the bus |
| hold_ack_o | output | 1 | Bus handed over |

## Verification
The assertions check these properties on every cycle:
- the address strobe lasts one cycle;
- the strobes are exclusive of each other and of the address strobe;
- a strobe follows the address strobe;
- completion follows an active strobe;
- the pads are released during hold;
- the acknowledge starts only at a cycle boundary;
- readiness is never shown under hold.

Other behaviour needs the bench's scenarios and its state-by-state reference model:
- that the read value is taken from the last state and not the middle one;
- that the port number replaces the upper address byte;
- that a hold request raised mid-cycle waits for S3;
- that back-to-back requests and the address extremes come out right.

// File: rtl/mbc_pkg.sv
package mbc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_S1   = 3'd1,
    ST_S2   = 3'd2,
    ST_S3   = 3'd3,
    ST_HOLD = 3'd4
  } bus_state_e;

  // strobe window of a cycle
  function automatic logic in_strobe(bus_state_e s);
    return (s == ST_S2) || (s == ST_S3);
  endfunction
endpackage

// File: rtl/mbc_seq.sv
module mbc_seq
  import mbc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       hold_req_i,
  output bus_state_e state_o,
  output logic       ready_o,
  output logic       take_o
);
  bus_state_e state_q, state_d;

  assign ready_o = (state_q == ST_IDLE) && !hold_req_i;
  assign take_o  = ready_o && req_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (hold_req_i) state_d = ST_HOLD;
               else if (req_i) state_d = ST_S1;
      ST_S1:   state_d = ST_S2;
      ST_S2:   state_d = ST_S3;
      ST_S3:   state_d = hold_req_i ? ST_HOLD : ST_IDLE;
      ST_HOLD: state_d = hold_req_i ? ST_HOLD : ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;

  assign state_o = state_q;

  // R9: hold entered only from a cycle boundary
  assert_hold_entry_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOLD && $past(state_q) != ST_HOLD)
      |-> ($past(state_q) == ST_IDLE || $past(state_q) == ST_S3));
  // R2: a taken request always opens with S1
  assert_take_opens_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> state_q == ST_S1);
endmodule

// File: rtl/mbc_req_latch.sv
module mbc_req_latch #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic              we_i,
  input  logic              io_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              we_o,
  output logic              io_o,
  output logic [DATA_W-1:0] lo_o,
  output logic [HI_W-1:0]   hi_o,
  output logic [DATA_W-1:0] wdata_o
);
  logic              we_q, io_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [HI_W-1:0]   port_rep;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      we_q    <= 1'b0;
      io_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (take_i) begin
      we_q    <= we_i;
      io_q    <= io_i;
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end

  // port number repeated across the upper address pins
  for (genvar b = 0; b < HI_W; b++) begin : g_rep
    assign port_rep[b] = addr_q[b % DATA_W];
  end

  assign we_o    = we_q;
  assign io_o    = io_q;
  assign lo_o    = addr_q[DATA_W-1:0];
  assign hi_o    = io_q ? port_rep : addr_q[ADDR_W-1:DATA_W];
  assign wdata_o = wdata_q;
endmodule

// File: rtl/mbc_pins.sv
module mbc_pins
  import mbc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int HI_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  bus_state_e        state_i,
  input  logic              we_i,
  input  logic              io_i,
  input  logic [DATA_W-1:0] lo_i,
  input  logic [HI_W-1:0]   hi_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] mux_o,
  output logic              mux_oe_o,
  output logic [HI_W-1:0]   addr_hi_o,
  output logic              ctl_oe_o,
  output logic              addr_stb_o,
  output logic              sel_io_o,
  output logic              rd_stb_no,
  output logic              wr_stb_no,
  output logic              hold_ack_o
);
  logic strobe_win;
  assign strobe_win = in_strobe(state_i);

  always_comb begin
    addr_stb_o = (state_i == ST_S1);
    hold_ack_o = (state_i == ST_HOLD);
    ctl_oe_o   = !hold_ack_o;
    mux_oe_o   = addr_stb_o || (strobe_win && we_i);
    mux_o      = addr_stb_o ? lo_i : wdata_i;
    addr_hi_o  = hi_i;
    sel_io_o   = io_i;
    rd_stb_no  = !(strobe_win && !we_i);
    wr_stb_no  = !(strobe_win && we_i);
  end

  // R12: strobes exclusive of each other and of address strobe
  assert_strobe_excl_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_stb_no && !wr_stb_no) && !(addr_stb_o && !(rd_stb_no && wr_stb_no)));
  // R10: pads released while bus is handed over
  assert_release_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_ack_o |-> !mux_oe_o && !ctl_oe_o && !addr_stb_o && rd_stb_no && wr_stb_no);
endmodule

// File: rtl/mbc_capture.sv
module mbc_capture
  import mbc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  bus_state_e        state_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] mux_i,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic              done_q;
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= (state_i == ST_S3);
      if (state_i == ST_S3 && !we_i) rdata_q <= mux_i;
    end

  assign done_o  = done_q;
  assign rdata_o = rdata_q;

  // R7: completion is a single-cycle pulse
  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/muxbus_cycle_ctrl.sv
module muxbus_cycle_ctrl
  import mbc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic              req_io_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] mux_o,
  output logic              mux_oe_o,
  input  logic [DATA_W-1:0] mux_i,
  output logic [HI_W-1:0]   addr_hi_o,
  output logic              ctl_oe_o,
  output logic              addr_stb_o,
  output logic              sel_io_o,
  output logic              rd_stb_no,
  output logic              wr_stb_no,
  input  logic              hold_req_i,
  output logic              hold_ack_o
);
  bus_state_e        state;
  logic              take, we_q, io_q;
  logic [DATA_W-1:0] lo_q, wdata_q;
  logic [HI_W-1:0]   hi_q;

  mbc_seq i_seq (
    .clk_i, .rst_ni, .req_i, .hold_req_i,
    .state_o(state), .ready_o(req_ready_o), .take_o(take)
  );

  mbc_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_latch (
    .clk_i, .rst_ni, .take_i(take), .we_i(req_we_i), .io_i(req_io_i),
    .addr_i(req_addr_i), .wdata_i(req_wdata_i),
    .we_o(we_q), .io_o(io_q), .lo_o(lo_q), .hi_o(hi_q), .wdata_o(wdata_q)
  );

  mbc_pins #(.DATA_W(DATA_W), .HI_W(HI_W)) i_pins (
    .clk_i, .rst_ni, .state_i(state), .we_i(we_q), .io_i(io_q),
    .lo_i(lo_q), .hi_i(hi_q), .wdata_i(wdata_q),
    .mux_o, .mux_oe_o, .addr_hi_o, .ctl_oe_o, .addr_stb_o, .sel_io_o,
    .rd_stb_no, .wr_stb_no, .hold_ack_o
  );

  mbc_capture #(.DATA_W(DATA_W)) i_cap (
    .clk_i, .rst_ni, .state_i(state), .we_i(we_q), .mux_i,
    .done_o, .rdata_o
  );

  // R2: address strobe lasts exactly one cycle
  assert_addr_stb_once_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_stb_o |=> !addr_stb_o);
  // R5: a strobe follows the address state
  assert_strobe_follows_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_stb_o |=> (!rd_stb_no || !wr_stb_no));
  // R7: completion only after an active strobe
  assert_done_after_strobe_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(!rd_stb_no || !wr_stb_no));
  // R9: acknowledge rises only after a sampled request
  assert_ack_rise_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold_ack_o) |-> $past(hold_req_i));
  // R11: never ready under hold
  assert_ready_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !hold_req_i && !hold_ack_o && !addr_stb_o);
endmodule

// File: tb/test_muxbus_cycle_ctrl.sv
module test_muxbus_cycle_ctrl;
  logic        clk = 0, rst_n = 0;
  logic        req = 0, we = 0, io = 0, hold = 0;
  logic [15:0] addr = 0;
  logic [7:0]  wdata = 0, mux_in = 0, dev_val = 0, junk = 8'h11;
  logic        ready, done, mux_oe, ctl_oe, astb, sel_io, rd_n, wr_n, ack;
  logic [7:0]  rdata, mux_out, hi;

  always #5 clk = ~clk;

  muxbus_cycle_ctrl i_muxbus_cycle_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_ready_o(ready),
    .req_we_i(we), .req_io_i(io), .req_addr_i(addr), .req_wdata_i(wdata),
    .done_o(done), .rdata_o(rdata), .mux_o(mux_out), .mux_oe_o(mux_oe),
    .mux_i(mux_in), .addr_hi_o(hi), .ctl_oe_o(ctl_oe), .addr_stb_o(astb),
    .sel_io_o(sel_io), .rd_stb_no(rd_n), .wr_stb_no(wr_n),
    .hold_req_i(hold), .hold_ack_o(ack)
  );

  // reference model: 0 idle, 1..3 cycle states, 4 hold
  int          ph = 0;
  bit          m_we, m_io, acc = 0, m_done = 0;
  logic [15:0] m_addr;
  logic [7:0]  m_wd, m_rdata = 0;
  int          errors = 0, checks = 0, cyc = 0;
  bit          started = 0, over = 0;

  always @(posedge clk) begin
    started = 1;
    acc = 0;
    if (!rst_n) begin
      ph = 0; m_done = 0; m_rdata = 0;
    end else begin
      m_done = (ph == 3);
      if (ph == 3 && !m_we) m_rdata = mux_in;
      case (ph)
        0: if (hold) ph = 4;
           else if (req) begin
             acc = 1; ph = 1; m_we = we; m_io = io; m_addr = addr; m_wd = wdata;
           end
        1: ph = 2;
        2: ph = 3;
        3: ph = hold ? 4 : 0;
        default: ph = hold ? 4 : 0;
      endcase
    end
  end

  // external device drives valid read data only in S3
  always @(negedge clk) begin
    junk   <= junk + 8'h25;
    mux_in <= (ph == 3) ? dev_val : junk;
  end

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s t=%0t actual=%0h expected=%0h", r, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (started && !over) begin
      automatic bit act_cyc = (ph >= 1 && ph <= 3);
      automatic bit strb = (ph == 2 || ph == 3);
      chk("R1 R11 ready", ready, (ph == 0) && !hold);
      chk("R2 addr_stb", astb, ph == 1);
      chk("R2 R5 R6 R10 mux_oe", mux_oe, (ph == 1) || (strb && m_we));
      chk("R5 R12 rd_stb", rd_n, !(strb && !m_we));
      chk("R6 R12 wr_stb", wr_n, !(strb && m_we));
      chk("R9 R10 hold_ack", ack, ph == 4);
      chk("R10 ctl_oe", ctl_oe, ph != 4);
      chk("R7 done", done, m_done);
      chk("R1 R7 rdata", rdata, m_rdata);
      if (ph == 1) chk("R2 R8 mux_o addr", mux_out, m_addr[7:0]);
      if (strb && m_we) chk("R6 mux_o data", mux_out, m_wd);
      if (act_cyc) begin
        chk("R3 R8 addr_hi", hi, m_io ? m_addr[7:0] : m_addr[15:8]);
        chk("R4 sel_io", sel_io, m_io);
      end
    end
  end

  task automatic finish_run();
    over = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !over) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  task automatic do_req(input bit w, input bit i, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    req = 1; we = w; io = i; addr = a; wdata = d;
    forever begin
      @(posedge clk); #1;
      if (acc) break;
    end
    @(negedge clk);
    req = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rst_n = 1;                               // R1 checked during reset
    idle(2);
    do_req(1, 0, 16'h1234, 8'hAB); idle(4);  // R3 R6 memory write
    dev_val = 8'h3C;
    do_req(0, 0, 16'h8050, 8'h00); idle(4);  // R5 R7 memory read
    do_req(1, 1, 16'h77F8, 8'h55); idle(4);  // R8 I/O write, upper byte ignored
    dev_val = 8'hC7;
    do_req(0, 1, 16'h998C, 8'h00); idle(4);  // R4 R8 I/O read
    do_req(1, 0, 16'h0000, 8'h00); idle(4);  // boundary addresses
    dev_val = 8'hFF;
    do_req(0, 0, 16'hFFFF, 8'h00); idle(4);
    // R11: hold in idle blocks a pending request
    @(negedge clk); hold = 1;
    fork begin idle(5); hold = 0; end join_none
    dev_val = 8'h5E;
    do_req(0, 0, 16'h4321, 8'h00); idle(4);
    // R9: hold raised in S1 waits for end of S3
    do_req(1, 0, 16'hA55A, 8'h96);
    hold = 1; idle(7); hold = 0; idle(3);
    // back-to-back requests
    dev_val = 8'h81;
    do_req(0, 1, 16'h0001, 8'h00);
    do_req(1, 0, 16'hBEEF, 8'h42); idle(6);
    finish_run();
  end
endmodule